// File: doc/BRIEF.md
# Windowed Watchdog with Reset Generator

This block supervises an external host controller. The host arms it by writing 1 to an enable bit. From then on the host has to write that bit again inside a time window to restart the timer. The window opens `WIN_MIN` cycles after the last restart and closes `TIMEOUT` cycles after it. A write that comes before the window opens counts as a fault. So does a window that passes with no write. Either fault drives an active-low reset output for a fixed number of cycles and disarms the watchdog.

The same reset output is held low while the power-on reset input is asserted. It stays low for `PULSE_LEN` cycles after that input is released, so the host gets a clean start at power-up. A boot flag tells the host, once it runs again, what caused its last reset. The flag is 1 (warm) after a watchdog reset and 0 (cold) after a power-on reset, and reading it clears it. A synchronous hard-clear input returns everything to the disabled state and does not pulse the reset output.

Top module: `wdt_window`

## Requirements
- R1: While `por_n` is low, and for exactly `PULSE_LEN` clock edges after it rises, `rst_out_n` is 0. During this time `wd_en` and `boot_warm` are 0.
- R2: A write (`ctl_wr`=1, `ctl_wen`=1) while the watchdog is disabled sets `wd_en` to 1 and starts the timer without causing a reset. With no further write, no reset occurs before clock edge `TIMEOUT` counted from the enabling edge.
- R3: While the watchdog is enabled, a write of 1 sampled k edges after the previous enable or restart, with `WIN_MIN` <= k <= `TIMEOUT`, restarts the timer. `rst_out_n` stays 1 and `wd_en` stays 1.
- R4: While the watchdog is enabled, a write of 1 sampled k edges after the previous enable or restart, with k < `WIN_MIN` (k = 1 included), is a fault. `rst_out_n` is 0 right after that edge.
- R5: If no write is sampled, a fault occurs at edge `TIMEOUT` counted from the last enable or restart. `rst_out_n` is 0 right after that edge.
- R6: After a fault, `rst_out_n` is 0 for exactly `PULSE_LEN` cycles and then returns to 1. `wd_en` is 0 from the fault onward.
- R7: A fault sets `boot_warm` to 1. A `boot_rd` strobe clears it on the next edge, except when a fault happens on the same edge, in which case the flag stays set.
- R8: A write of 0 disables the watchdog (`wd_en`=0). No reset follows, however long the host then waits.
- R9: `hard_clr`=1 clears `wd_en`, `boot_warm` and the timer at the next edge. It ends any reset pulse in progress (`rst_out_n`=1) and never starts one.
- R10: Control writes sampled while `rst_out_n` is 0 are ignored. `wd_en` stays 0 during the pulse and after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset from the supply monitor, active low |
| hard_clr | input | 1 | Synchronous hard clear, active high |
| ctl_wr | input | 1 | Host write strobe for the enable bit |
| ctl_wen | input | 1 | Value written to the enable bit |
| boot_rd | input | 1 | Host read strobe for the boot flag; clears the flag |
| wd_en | output | 1 | Current state of the enable bit |
| boot_warm | output | 1 | Boot flag: 1 = last reset came from the watchdog |
| rst_out_n | output | 1 | Reset output to the host, active low |

## Verification
If the timer is off by a single count, a kick placed exactly at `WIN_MIN` or at `TIMEOUT` either raises a false reset or lets an early kick through. The bench therefore drives kicks on those boundary edges and one edge before them, and reads `rst_out_n` in the very next cycle. If the pulse counter is wrong, the length of the low phase comes out wrong; this shows at its trailing edge `PULSE_LEN` cycles later. If the enable or boot state survives a fault or a hard clear, `wd_en` or `boot_warm` shows it one cycle after the event. A lost enable bit shows as a missing timeout reset after a long idle wait.

// File: rtl/wdt_window.sv
module wdt_window #(
  parameter int WIN_MIN   = 256,
  parameter int TIMEOUT   = 4096,
  parameter int PULSE_LEN = 64
) (
  input  logic clk,
  input  logic por_n,
  input  logic hard_clr,
  input  logic ctl_wr,
  input  logic ctl_wen,
  input  logic boot_rd,
  output logic wd_en,
  output logic boot_warm,
  output logic rst_out_n
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam logic [TW-1:0] WIN_V = TW'(WIN_MIN);
  localparam logic [TW-1:0] TO_V  = TW'(TIMEOUT);
  localparam logic [PW-1:0] PUL_V = PW'(PULSE_LEN);

  logic [TW-1:0] timer;
  logic [PW-1:0] pcnt;
  logic en_q, boot_q;

  assign rst_out_n = (pcnt == '0);
  assign wd_en     = en_q;
  assign boot_warm = boot_q;

  wire acc_wr = ctl_wr & rst_out_n;
  wire kick   = acc_wr & ctl_wen & en_q;
  wire early  = kick & (timer < WIN_V);
  wire late   = en_q & ~acc_wr & (timer == TO_V);
  wire fault  = early | late;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en_q   <= 1'b0;
      boot_q <= 1'b0;
      timer  <= '0;
      pcnt   <= PUL_V;
    end else if (hard_clr) begin
      en_q   <= 1'b0;
      boot_q <= 1'b0;
      timer  <= '0;
      pcnt   <= '0;
    end else if (fault) begin
      en_q   <= 1'b0;
      boot_q <= 1'b1;
      timer  <= '0;
      pcnt   <= PUL_V;
    end else begin
      if (pcnt != '0) pcnt <= pcnt - 1'b1;
      if (acc_wr) begin
        en_q  <= ctl_wen;
        timer <= ctl_wen ? TW'(1) : '0;
      end else if (en_q) begin
        timer <= timer + 1'b1;
      end
      if (boot_rd) boot_q <= 1'b0;
    end
  end

  // R4 R5 R6 R7
  fault_effect_chk: assert property (@(posedge clk) disable iff (!por_n)
    fault && !hard_clr |=> !rst_out_n && !wd_en && boot_warm);

  // R3
  kick_ok_chk: assert property (@(posedge clk) disable iff (!por_n)
    kick && !early && !hard_clr |=> rst_out_n && wd_en);

  // R9
  hard_clr_chk: assert property (@(posedge clk) disable iff (!por_n)
    hard_clr |=> rst_out_n && !wd_en && !boot_warm && timer == '0);

  // R10
  pulse_disarm_chk: assert property (@(posedge clk) disable iff (!por_n)
    !rst_out_n && !hard_clr |=> !wd_en);

  // R7
  boot_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    boot_rd && !fault |=> !boot_warm);

  // R6
  pulse_start_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_out_n) |-> pcnt == PUL_V);
endmodule

// File: tb/wdt_window_tb.sv
module wdt_window_tb;
  localparam int CLK_P = 10;
  localparam int WIN = 8;
  localparam int TO  = 32;
  localparam int PL  = 6;

  logic clk = 1'b0;
  logic por_n = 1'b0, hard_clr = 1'b0, ctl_wr = 1'b0, ctl_wen = 1'b0, boot_rd = 1'b0;
  logic wd_en, boot_warm, rst_out_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  wdt_window #(.WIN_MIN(WIN), .TIMEOUT(TO), .PULSE_LEN(PL)) u_dut (
    .clk(clk), .por_n(por_n), .hard_clr(hard_clr), .ctl_wr(ctl_wr),
    .ctl_wen(ctl_wen), .boot_rd(boot_rd), .wd_en(wd_en),
    .boot_warm(boot_warm), .rst_out_n(rst_out_n));

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic v);
    ctl_wr = 1'b1; ctl_wen = v;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wen = 1'b0;
  endtask

  task automatic rd();
    boot_rd = 1'b1;
    @(negedge clk);
    boot_rd = 1'b0;
  endtask

  task automatic hclr();
    hard_clr = 1'b1;
    @(negedge clk);
    hard_clr = 1'b0;
  endtask

  task automatic t_por();
    step(3);
    chk("R1 rst during por", rst_out_n, 1'b0);
    por_n = 1'b1;
    chk("R1 en after por", wd_en, 1'b0);
    chk("R1 boot after por", boot_warm, 1'b0);
    step(PL - 1);
    chk("R1 rst still low", rst_out_n, 1'b0);
    step(1);
    chk("R1 rst released", rst_out_n, 1'b1);
  endtask

  task automatic t_timeout();
    wr(1'b1);
    chk("R2 enabled", wd_en, 1'b1);
    chk("R2 no reset on enable", rst_out_n, 1'b1);
    step(TO - 1);
    chk("R2 no reset before timeout", rst_out_n, 1'b1);
    step(1);
    chk("R5 reset at timeout", rst_out_n, 1'b0);
    chk("R6 en cleared", wd_en, 1'b0);
    chk("R7 boot set", boot_warm, 1'b1);
    step(PL - 1);
    chk("R6 pulse still low", rst_out_n, 1'b0);
    step(1);
    chk("R6 pulse ended", rst_out_n, 1'b1);
    rd();
    chk("R7 boot cleared by read", boot_warm, 1'b0);
  endtask

  task automatic t_window();
    hclr();
    wr(1'b1);
    step(WIN - 1);
    wr(1'b1);
    chk("R3 kick at WIN_MIN", rst_out_n, 1'b1);
    chk("R3 still enabled", wd_en, 1'b1);
    step(TO - 1);
    wr(1'b1);
    chk("R3 kick at TIMEOUT", rst_out_n, 1'b1);
    step(TO - 1);
    chk("R3 restart held timer", rst_out_n, 1'b1);
    step(1);
    chk("R5 timeout after restart", rst_out_n, 1'b0);
  endtask

  task automatic t_early();
    hclr();
    rd();
    wr(1'b1);
    step(WIN - 2);
    wr(1'b1);
    chk("R4 kick at WIN_MIN-1", rst_out_n, 1'b0);
    chk("R4 en cleared", wd_en, 1'b0);
    chk("R7 boot after early", boot_warm, 1'b1);
    hclr();
    wr(1'b1);
    wr(1'b1);
    chk("R4 kick at 1", rst_out_n, 1'b0);
  endtask

  task automatic t_disable();
    hclr();
    wr(1'b1);
    step(5);
    wr(1'b0);
    chk("R8 disabled", wd_en, 1'b0);
    step(TO + 10);
    chk("R8 no reset", rst_out_n, 1'b1);
    chk("R8 no boot", boot_warm, 1'b0);
  endtask

  task automatic t_hclr();
    hclr();
    wr(1'b1);
    step(TO);
    chk("R9 pre fault", rst_out_n, 1'b0);
    hclr();
    chk("R9 pulse ended", rst_out_n, 1'b1);
    chk("R9 boot cleared", boot_warm, 1'b0);
    chk("R9 en cleared", wd_en, 1'b0);
    wr(1'b1);
    step(4);
    hclr();
    chk("R9 no pulse", rst_out_n, 1'b1);
    step(TO + 5);
    chk("R9 timer stopped", rst_out_n, 1'b1);
  endtask

  task automatic t_ignore();
    hclr();
    wr(1'b1);
    step(TO);
    wr(1'b1);
    chk("R10 write ignored", wd_en, 1'b0);
    step(PL);
    chk("R10 pulse over", rst_out_n, 1'b1);
    chk("R10 still disabled", wd_en, 1'b0);
    step(TO + 2);
    chk("R10 no second reset", rst_out_n, 1'b1);
  endtask

  task automatic t_boot_race();
    hclr();
    wr(1'b1);
    step(TO - 1);
    rd();
    chk("R7 fault beats read", boot_warm, 1'b1);
    chk("R7 fault happened", rst_out_n, 1'b0);
  endtask

  initial begin
    t_por();
    t_timeout();
    t_window();
    t_early();
    t_disable();
    t_hclr();
    t_ignore();
    t_boot_race();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule